// File: doc/BRIEF.md
# Multi-cycle multiply and multiply-accumulate unit

This block is the multiply execution unit of a 32-bit RISC core. The core hands it one decoded 16-bit instruction word together with two 32-bit register operands and pulses `start`. The unit then works for one to four cycles and deposits the outcome in a 64-bit accumulator. The accumulator is kept as two 32-bit halves, `acc_hi` and `acc_lo`, which are always visible on the ports. Software can load either half while the unit is idle.

There are seven operations. Two are full 32×32→64 multiplies, one signed and one unsigned. One is a 32×32 multiply that keeps only the low word. Two are 16×16→32 multiplies, one signed and one unsigned. The last two are signed multiply-accumulates: one 32×32 and one 16×16, each added into the full 64-bit accumulator. The opcode fields that name registers (bits 11:8 and 7:4) are don't-care, because the operands arrive on their own ports.

A single 16×32 unsigned multiplier does all the work on operand magnitudes, and the sign is applied when the result is written. The controller is a state machine with these states:
- `ST_IDLE`: waiting for a start.
- `ST_SHORT`: the single cycle of a 16-bit form.
- `ST_LO`: low half × low half.
- `ST_BH`: low half of one operand × upper half of the other.
- `ST_AH`: upper half × the whole other operand.
- `ST_FIN`: sign fix and write-back.

The transitions are:
- `ST_IDLE`→`ST_SHORT` on a 16-bit start.
- `ST_IDLE`→`ST_LO` on a 32-bit start.
- `ST_LO`→`ST_BH` when the upper half of `opnd_n`'s magnitude is nonzero; otherwise `ST_LO`→`ST_AH` when the upper half of `opnd_m`'s magnitude is nonzero; otherwise `ST_LO`→`ST_FIN`.
- `ST_BH`→`ST_AH` when the upper half of `opnd_m`'s magnitude is nonzero; otherwise `ST_BH`→`ST_FIN`.
- `ST_AH`→`ST_FIN`.
- `ST_SHORT`→`ST_IDLE` and `ST_FIN`→`ST_IDLE`.

Top module: `mac_unit`

## Requirements
- R1: An operation is started only when `start` is high in an idle cycle and the opcode matches one of seven patterns on bits [15:12] and [3:0]: 0011/1101 signed 32×32→64, 0011/0101 unsigned 32×32→64, 0000/0111 32×32→32, 0010/1111 signed 16×16, 0010/1110 unsigned 16×16, 0000/1111 signed 32-bit accumulate, 0100/1111 signed 16-bit accumulate. With any other opcode, `busy` stays low and the accumulator is unchanged.
- R2: The signed 32×32 form writes the full two's-complement 64-bit product: bits 63:32 to `acc_hi` and bits 31:0 to `acc_lo`.
- R3: The unsigned 32×32 form writes the full unsigned 64-bit product to `acc_hi`:`acc_lo`.
- R4: The 32×32→32 form writes the low 32 bits of the product to `acc_lo` and leaves `acc_hi` unchanged.
- R5: The 16×16 forms use only bits 15:0 of each operand. They sign-extend those bits for the signed form and zero-extend them for the unsigned form, write the 32-bit product to `acc_lo`, and leave `acc_hi` unchanged.
- R6: The 32-bit accumulate form adds the signed 64-bit product of both operands to `{acc_hi,acc_lo}`, modulo 2^64.
- R7: The 16-bit accumulate form adds the signed product of the sign-extended low 16 bits to `{acc_hi,acc_lo}`, modulo 2^64.
- R8: After an accepted start, `busy` is high for exactly N cycles, and then `done` is high for exactly one cycle with `busy` low, at the moment the result becomes visible. N is 1 for the 16-bit forms. For the 32-bit forms, N is 2 plus one for each operand whose magnitude has a nonzero upper half (bits 31:16). The magnitude is the absolute value for the signed forms and the raw value otherwise.
- R9: A `start` seen while `busy` is high is ignored. The running operation finishes with its own operands and timing.
- R10: In an idle cycle, `wr_hi` and `wr_lo` load `wr_data` into `acc_hi` and `acc_lo`. While busy, these writes are ignored and the accumulator holds until the result is written.
- R11: Synchronous reset clears both accumulator halves, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation named by `opcode` |
| opcode | input | 16 | Instruction word |
| opnd_n | input | 32 | First register operand |
| opnd_m | input | 32 | Second register operand |
| wr_hi | input | 1 | Load `wr_data` into the high accumulator half |
| wr_lo | input | 1 | Load `wr_data` into the low accumulator half |
| wr_data | input | 32 | Accumulator load value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| acc_hi | output | 32 | High accumulator half |
| acc_lo | output | 32 | Low accumulator half |

## Verification
The assertions assume that `rst` is held for at least one clock before any start, and that the inputs settle before each rising edge. They also assume that software accumulator loads may coincide with a start only in an idle cycle. The bench drives every input on the falling edge, so it stays inside these assumptions. Its stimulus deliberately includes unrecognised opcodes, starts held high across busy cycles, and loads issued while busy. These all fall inside the behaviour the properties cover, rather than outside it.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OPC_W = 16;

    typedef enum logic [2:0] {
        K_NONE, K_SMUL64, K_UMUL64, K_MUL32,
        K_SMUL16, K_UMUL16, K_SMAC32, K_SMAC16
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SHORT, ST_LO, ST_BH, ST_AH, ST_FIN
    } state_e;

    function automatic logic kind_short(kind_e k);
        return (k == K_SMUL16) || (k == K_UMUL16) || (k == K_SMAC16);
    endfunction

    function automatic logic kind_signed(kind_e k);
        return (k == K_SMUL64) || (k == K_SMAC32) || (k == K_SMUL16) || (k == K_SMAC16);
    endfunction

    function automatic logic kind_accum(kind_e k);
        return (k == K_SMAC32) || (k == K_SMAC16);
    endfunction

    function automatic logic kind_low_only(kind_e k);
        return (k == K_MUL32) || (k == K_SMUL16) || (k == K_UMUL16);
    endfunction
endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output kind_e            kind
);
    logic [7:0] key;

    always_comb begin
        key = {opcode[15:12], opcode[3:0]};
        case (key)
            8'b0011_1101: kind = K_SMUL64;
            8'b0011_0101: kind = K_UMUL64;
            8'b0000_0111: kind = K_MUL32;
            8'b0010_1111: kind = K_SMUL16;
            8'b0010_1110: kind = K_UMUL16;
            8'b0000_1111: kind = K_SMAC32;
            8'b0100_1111: kind = K_SMAC16;
            default:      kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/mac_operand.sv
module mac_operand
    import mac_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_raw,
    input  logic [XLEN-1:0] b_raw,
    input  kind_e           kind,
    output logic [XLEN-1:0] mag_a,
    output logic [XLEN-1:0] mag_b,
    output logic            neg
);
    localparam int HALF = XLEN / 2;

    logic            short_f, sgn_f, a_neg, b_neg;
    logic [XLEN-1:0] ext_a, ext_b;

    always_comb begin
        short_f = kind_short(kind);
        sgn_f   = kind_signed(kind);
        if (short_f) begin
            ext_a = sgn_f ? {{HALF{a_raw[HALF-1]}}, a_raw[HALF-1:0]}
                          : {{HALF{1'b0}}, a_raw[HALF-1:0]};
            ext_b = sgn_f ? {{HALF{b_raw[HALF-1]}}, b_raw[HALF-1:0]}
                          : {{HALF{1'b0}}, b_raw[HALF-1:0]};
        end else begin
            ext_a = a_raw;
            ext_b = b_raw;
        end
        a_neg = sgn_f & ext_a[XLEN-1];
        b_neg = sgn_f & ext_b[XLEN-1];
        mag_a = a_neg ? (~ext_a + 1'b1) : ext_a;
        mag_b = b_neg ? (~ext_b + 1'b1) : ext_b;
        neg   = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mac_partial.sv
module mac_partial
    import mac_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  state_e              st,
    input  logic [XLEN-1:0]     mag_a,
    input  logic [XLEN-1:0]     mag_b,
    output logic [2*XLEN-1:0]   term
);
    localparam int HALF  = XLEN / 2;
    localparam int PROD_W = XLEN + HALF;

    logic [HALF-1:0]   x;
    logic [XLEN-1:0]   y;
    logic [PROD_W-1:0] prod;
    logic              shift_up;

    always_comb begin
        x        = '0;
        y        = '0;
        shift_up = 1'b0;
        case (st)
            ST_SHORT, ST_LO: begin
                x = mag_a[HALF-1:0];
                y = {{HALF{1'b0}}, mag_b[HALF-1:0]};
            end
            ST_BH: begin
                x = mag_a[HALF-1:0];
                y = {mag_b[XLEN-1:HALF], {HALF{1'b0}}};
            end
            ST_AH: begin
                x        = mag_a[XLEN-1:HALF];
                y        = mag_b;
                shift_up = 1'b1;
            end
            default: begin
                x = '0;
                y = '0;
            end
        endcase
        prod = {{XLEN{1'b0}}, x} * {{HALF{1'b0}}, y};
        term = shift_up ? {prod, {HALF{1'b0}}} : {{HALF{1'b0}}, prod};
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      opcode,
    input  logic [XLEN-1:0]  opnd_n,
    input  logic [XLEN-1:0]  opnd_m,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [XLEN-1:0]  wr_data,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  acc_hi,
    output logic [XLEN-1:0]  acc_lo
);
    localparam int HALF  = XLEN / 2;
    localparam int ACC_W = 2 * XLEN;

    state_e          st, nxt;
    kind_e           dec_kind, kind_q;
    logic [XLEN-1:0] pre_a, pre_b, mag_a_q, mag_b_q;
    logic            pre_neg, neg_q;
    logic [ACC_W-1:0] psum_q, term, src, res, acc_sum;
    logic            accept, a_hi_nz, b_hi_nz;

    mac_decode u_dec (
        .opcode (opcode),
        .kind   (dec_kind)
    );

    mac_operand #(.XLEN(XLEN)) u_opnd (
        .a_raw (opnd_m),
        .b_raw (opnd_n),
        .kind  (dec_kind),
        .mag_a (pre_a),
        .mag_b (pre_b),
        .neg   (pre_neg)
    );

    mac_partial #(.XLEN(XLEN)) u_part (
        .st    (st),
        .mag_a (mag_a_q),
        .mag_b (mag_b_q),
        .term  (term)
    );

    assign accept  = (st == ST_IDLE) && start && (dec_kind != K_NONE);
    assign a_hi_nz = |mag_a_q[XLEN-1:HALF];
    assign b_hi_nz = |mag_b_q[XLEN-1:HALF];
    assign busy    = (st != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (accept) nxt = kind_short(dec_kind) ? ST_SHORT : ST_LO;
            ST_SHORT: nxt = ST_IDLE;
            ST_LO:    nxt = b_hi_nz ? ST_BH : (a_hi_nz ? ST_AH : ST_FIN);
            ST_BH:    nxt = a_hi_nz ? ST_AH : ST_FIN;
            ST_AH:    nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // result shaping
    always_comb begin
        src     = (st == ST_SHORT) ? term : psum_q;
        res     = neg_q ? (~src + 1'b1) : src;
        acc_sum = {acc_hi, acc_lo} + res;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi  <= '0;
            acc_lo  <= '0;
            done    <= 1'b0;
            psum_q  <= '0;
            mag_a_q <= '0;
            mag_b_q <= '0;
            neg_q   <= 1'b0;
            kind_q  <= K_NONE;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (wr_hi) acc_hi <= wr_data;
                    if (wr_lo) acc_lo <= wr_data;
                    if (accept) begin
                        mag_a_q <= pre_a;
                        mag_b_q <= pre_b;
                        neg_q   <= pre_neg;
                        kind_q  <= dec_kind;
                    end
                end
                ST_LO:        psum_q <= term;
                ST_BH, ST_AH: psum_q <= psum_q + term;
                ST_SHORT, ST_FIN: begin
                    done <= 1'b1;
                    if (kind_accum(kind_q)) begin
                        acc_hi <= acc_sum[ACC_W-1:XLEN];
                        acc_lo <= acc_sum[XLEN-1:0];
                    end else if (kind_low_only(kind_q)) begin
                        acc_lo <= res[XLEN-1:0];
                    end else begin
                        acc_hi <= res[ACC_W-1:XLEN];
                        acc_lo <= res[XLEN-1:0];
                    end
                end
                default: done <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [15:0]     opcode,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] acc_hi,
    input logic [XLEN-1:0] acc_lo
);
    logic       legal, short_op;
    logic [2:0] busy_run;

    always_comb begin
        legal = (opcode[15:12] == 4'b0011 && opcode[3:0] == 4'b1101) ||
                (opcode[15:12] == 4'b0011 && opcode[3:0] == 4'b0101) ||
                (opcode[15:12] == 4'b0000 && opcode[3:0] == 4'b0111) ||
                (opcode[15:12] == 4'b0010 && opcode[3:0] == 4'b1111) ||
                (opcode[15:12] == 4'b0010 && opcode[3:0] == 4'b1110) ||
                (opcode[15:12] == 4'b0000 && opcode[3:0] == 4'b1111) ||
                (opcode[15:12] == 4'b0100 && opcode[3:0] == 4'b1111);
        short_op = (opcode[15:12] == 4'b0010 && opcode[3:1] == 3'b111) ||
                   (opcode[15:12] == 4'b0100 && opcode[3:0] == 4'b1111);
    end

    always_ff @(posedge clk) begin
        if (rst)            busy_run <= '0;
        else if (!busy)     busy_run <= '0;
        else if (busy_run != 3'd7) busy_run <= busy_run + 3'd1;
    end

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !legal) |=> (!busy && $stable({acc_hi, acc_lo}))); // R1
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && legal) |=> busy); // R8
    AST_SHORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && short_op) |=> busy ##1 (done && !busy)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R8
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run <= 3'd3)); // R8
    AST_ACC_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done || $stable({acc_hi, acc_lo}))); // R10
endmodule

bind mac_unit mac_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opcode (opcode),
    .busy   (busy),
    .done   (done),
    .acc_hi (acc_hi),
    .acc_lo (acc_lo)
);

// File: tb/mac_unit_test.sv
module mac_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
    logic [15:0] opcode = '0;
    logic [31:0] opnd_n = '0, opnd_m = '0, wr_data = '0;
    logic        busy, done;
    logic [31:0] acc_hi, acc_lo;

    int errors = 0, checks = 0;
    bit compare_on = 1'b0;
    string cur_req = "R11";

    // reference model state
    int          rem = 0;
    int          m_kind = 0;
    logic [31:0] m_a, m_b;
    logic [63:0] exp_acc = '0;
    logic        exp_busy = 1'b0, exp_done = 1'b0;

    mac_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .opnd_n(opnd_n), .opnd_m(opnd_m), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .busy(busy), .done(done),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // kinds: 1 s64, 2 u64, 3 mul32, 4 s16, 5 u16, 6 smac32, 7 smac16, 0 none
    function automatic int kind_of(logic [15:0] op);
        if (op[15:12] == 4'h3 && op[3:0] == 4'hD) return 1;
        if (op[15:12] == 4'h3 && op[3:0] == 4'h5) return 2;
        if (op[15:12] == 4'h0 && op[3:0] == 4'h7) return 3;
        if (op[15:12] == 4'h2 && op[3:0] == 4'hF) return 4;
        if (op[15:12] == 4'h2 && op[3:0] == 4'hE) return 5;
        if (op[15:12] == 4'h0 && op[3:0] == 4'hF) return 6;
        if (op[15:12] == 4'h4 && op[3:0] == 4'hF) return 7;
        return 0;
    endfunction

    function automatic logic [15:0] mk_op(int k);
        logic [7:0] mid = 8'($urandom);
        case (k)
            1: return {4'h3, mid, 4'hD};
            2: return {4'h3, mid, 4'h5};
            3: return {4'h0, mid, 4'h7};
            4: return {4'h2, mid, 4'hF};
            5: return {4'h2, mid, 4'hE};
            6: return {4'h0, mid, 4'hF};
            7: return {4'h4, mid, 4'hF};
            default: return {4'h1, mid, 4'h0};
        endcase
    endfunction

    function automatic int cycles_of(int k, logic [31:0] a, logic [31:0] b);
        logic [31:0] ma = a, mb = b;
        if (k == 4 || k == 5 || k == 7) return 1;
        if (k == 1 || k == 6) begin
            if (a[31]) ma = -a;
            if (b[31]) mb = -b;
        end
        return 2 + int'(ma[31:16] != 0) + int'(mb[31:16] != 0);
    endfunction

    function automatic string req_of(int k);
        case (k)
            1: return "R2"; 2: return "R3"; 3: return "R4";
            4, 5: return "R5"; 6: return "R6"; 7: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [63:0] apply(int k, logic [31:0] a, logic [31:0] b, logic [63:0] acc);
        logic signed [63:0] sa = {{32{a[31]}}, a};
        logic signed [63:0] sb = {{32{b[31]}}, b};
        logic signed [63:0] s16a = {{48{a[15]}}, a[15:0]};
        logic signed [63:0] s16b = {{48{b[15]}}, b[15:0]};
        logic [63:0] p;
        case (k)
            1: return sa * sb;
            2: return {32'b0, a} * {32'b0, b};
            3: begin p = {32'b0, a} * {32'b0, b}; return {acc[63:32], p[31:0]}; end
            4: begin p = s16a * s16b; return {acc[63:32], p[31:0]}; end
            5: begin p = {48'b0, a[15:0]} * {48'b0, b[15:0]}; return {acc[63:32], p[31:0]}; end
            6: return acc + 64'(sa * sb);
            7: return acc + 64'(s16a * s16b);
            default: return acc;
        endcase
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            rem = 0; exp_acc = '0; exp_done = 1'b0;
        end else begin
            exp_done = 1'b0;
            if (rem > 0) begin
                rem = rem - 1;
                if (rem == 0) begin
                    exp_acc  = apply(m_kind, opnd_m_l, opnd_n_l, exp_acc);
                    exp_done = 1'b1;
                end
            end else begin
                if (wr_hi) exp_acc[63:32] = wr_data;
                if (wr_lo) exp_acc[31:0]  = wr_data;
                if (start && kind_of(opcode) != 0) begin
                    m_kind   = kind_of(opcode);
                    opnd_m_l = opnd_m;
                    opnd_n_l = opnd_n;
                    rem      = cycles_of(m_kind, opnd_m, opnd_n);
                end
            end
        end
        exp_busy = (rem > 0);
    end
    logic [31:0] opnd_m_l, opnd_n_l;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            check(busy == exp_busy, "R8", "busy", 64'(busy), 64'(exp_busy));
            check(done == exp_done, "R8", "done", 64'(done), 64'(exp_done));
            check({acc_hi, acc_lo} == exp_acc, cur_req, "accumulator", {acc_hi, acc_lo}, exp_acc);
        end
    end

    task automatic run_op(int k, logic [31:0] m, logic [31:0] n);
        int cyc = 0;
        int want = cycles_of(k, m, n);
        cur_req = req_of(k);
        @(negedge clk);
        start = 1'b1; opcode = mk_op(k); opnd_m = m; opnd_n = n;
        @(negedge clk);
        start = 1'b0; opnd_m = 32'($urandom); opnd_n = 32'($urandom);
        while (busy) begin cyc++; @(negedge clk); end
        if (k != 0) check(cyc == want, "R8", "busy length", 64'(cyc), 64'(want));
        else        check(cyc == 0, "R1", "illegal busy length", 64'(cyc), 64'd0);
    endtask

    task automatic load_acc(logic [31:0] hi, logic [31:0] lo);
        cur_req = "R10";
        @(negedge clk); wr_hi = 1'b1; wr_lo = 1'b1; wr_data = hi;
        @(negedge clk); wr_hi = 1'b0; wr_data = lo;
        @(negedge clk); wr_lo = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({acc_hi, acc_lo} == 64'd0, "R11", "reset acc", {acc_hi, acc_lo}, 64'd0);
        check(!busy && !done, "R11", "reset flags", {62'd0, busy, done}, 64'd0);
        compare_on = 1'b1;

        // R2 signed full product: 2, 3 and 4 cycle cases, most-negative value
        run_op(1, 32'd7, 32'hFFFF_FFFD);
        run_op(1, 32'h0001_0000, 32'd5);
        run_op(1, 32'h8000_0000, 32'h8000_0000);
        run_op(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R3 unsigned full product
        run_op(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(2, 32'h0000_1234, 32'h0002_0000);
        // R4 low word only, high half must survive
        load_acc(32'hDEAD_BEEF, 32'h0);
        run_op(3, 32'h1234_5678, 32'h9ABC_DEF0);
        check(acc_hi == 32'hDEAD_BEEF, "R4", "high half kept", 64'(acc_hi), 64'hDEAD_BEEF);
        // R5 16-bit forms ignore upper operand bits
        run_op(4, 32'hABCD_8000, 32'h1234_8000);
        run_op(4, 32'hFFFF_0003, 32'h0000_FFFE);
        run_op(5, 32'hABCD_FFFF, 32'h5555_FFFF);
        check(acc_lo == 32'hFFFE_0001, "R5", "unsigned 16 product", 64'(acc_lo), 64'hFFFE_0001);
        // R6 and R7 accumulate chains
        load_acc(32'h0, 32'h0);
        run_op(6, 32'hFFFF_FFFF, 32'd1);
        run_op(6, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        run_op(7, 32'h0000_8000, 32'h0000_7FFF);
        run_op(7, 32'h0000_FFFF, 32'h0000_FFFF);
        // R1 unrecognised opcodes
        run_op(0, 32'd3, 32'd4);
        check({acc_hi, acc_lo} == exp_acc, "R1", "illegal left acc", {acc_hi, acc_lo}, exp_acc);

        // R9 start held high through a four-cycle operation with another opcode
        cur_req = "R9";
        @(negedge clk);
        start = 1'b1; opcode = mk_op(2); opnd_m = 32'hFFFF_0001; opnd_n = 32'h0003_0002;
        @(negedge clk);
        opcode = mk_op(1); opnd_m = 32'd9; opnd_n = 32'd9;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check({acc_hi, acc_lo} == 64'hFFFF_0001 * 64'h0003_0002, "R9", "first op result",
              {acc_hi, acc_lo}, 64'hFFFF_0001 * 64'h0003_0002);

        // R10 writes during busy are ignored
        load_acc(32'h1111_1111, 32'h2222_2222);
        cur_req = "R10";
        @(negedge clk);
        start = 1'b1; opcode = mk_op(3); opnd_m = 32'h0001_0000; opnd_n = 32'h0001_0000;
        @(negedge clk);
        start = 1'b0; wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hCAFE_F00D;
        @(negedge clk);
        check(acc_hi == 32'h1111_1111, "R10", "write while busy", 64'(acc_hi), 64'h1111_1111);
        wr_hi = 1'b0; wr_lo = 1'b0;
        while (busy) @(negedge clk);
        check(acc_hi == 32'h1111_1111, "R10", "high after op", 64'(acc_hi), 64'h1111_1111);

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int k = int'($urandom_range(0, 7));
            logic [31:0] a = 32'($urandom), b = 32'($urandom);
            if ($urandom_range(0, 3) == 0) a = a & 32'h0000_FFFF;
            if ($urandom_range(0, 3) == 0) b = b | 32'hFFFF_0000;
            if ($urandom_range(0, 9) == 0) load_acc(32'($urandom), 32'($urandom));
            run_op(k, a, b);
        end

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule